// File: doc/BRIEF.md
# DMA Software-Start Trigger Register

This block is the control/status register through which the CPU launches a software-initiated DMA transfer. A halfword write to the upper half of the register carries a descriptor pointer. If the DMA engine is idle for software work, in its normal command mode and not halted on an error, the write is accepted. The pointer is latched, a pending-request flag goes to the transfer engine, and the completion status is cleared.

While the transfer runs, the engine may replace the pointer when it follows a chain start. The engine reports normal end, abnormal end or a wait-for-trigger condition, and each of these drops the request flag. Only a normal end sets the status flag. The status flag is cleared by a software-clear command, by a standby-transition command, or by the next accepted write. A level interrupt follows the status flag while the interrupt is enabled. The block also forms the descriptor address as a base plus the latched pointer.

Top module: `sw_start_reg`

## Requirements
- R1: After a synchronous reset with `rst_n` low, `rd_data` is 0, `sw_req` is 0 and `irq` is 0.
- R2: A write is a trigger only when `wr_en` is 1 and `wr_be` equals 4'b1100 (the upper halfword). Every other byte-enable pattern leaves the register unchanged, including 4'b1111 (full word) and 4'b0011 (lower halfword).
- R3: A trigger write is rejected and leaves the register unchanged in three cases: `sw_req` is already 1, `eng_mode` is not 2'b00 (normal), or `eng_estop` is 1.
- R4: An accepted trigger takes effect in the next cycle. The pointer is loaded from `wr_data[29:16]`, `sw_req` becomes 1 and the status flag becomes 0. `wr_data[31:30]` have no effect.
- R5: The readback `rd_data` holds the status flag in bit 31, the request flag in bit 30 and the pointer in bits 29:16. Bits 15:0 read as 0.
- R6: When `chain_load` is 1 while `sw_req` is 1, the pointer takes the value of `chain_ptr` in the next cycle.
- R7: Any of `evt_norm_end`, `evt_abort` or `evt_wait` clears `sw_req` in the next cycle. An accepted trigger in the same cycle takes priority.
- R8: `evt_norm_end` sets the status flag. `cmd_swclr` or `cmd_standby` clears it. A clear command wins over a normal end that arrives in the same cycle. `evt_abort` and `evt_wait` leave the flag as it is.
- R9: `irq` is 1 exactly when `irq_en` and the status flag are both 1. The output is combinational.
- R10: `desc_addr` equals `desc_base` plus the zero-extended pointer, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Write byte enables |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register readback |
| eng_mode | input | 2 | Engine command mode, 2'b00 = normal |
| eng_estop | input | 1 | Engine halted on error |
| evt_norm_end | input | 1 | Software transfer ended normally |
| evt_abort | input | 1 | Software transfer ended abnormally |
| evt_wait | input | 1 | Engine waits for a new trigger |
| chain_load | input | 1 | Chain start replaces the pointer |
| chain_ptr | input | 14 | Pointer used by the chain start |
| cmd_swclr | input | 1 | Software-clear command |
| cmd_standby | input | 1 | Standby-transition command |
| irq_en | input | 1 | Completion interrupt enable |
| desc_base | input | 32 | Descriptor area base address |
| sw_req | output | 1 | Pending software request to the engine |
| desc_addr | output | 32 | Descriptor address, base plus pointer |
| irq | output | 1 | Completion interrupt, level |

## Verification
Trigger writes are tried with each byte-enable shape: full word, lower halfword and upper halfword. Only the upper halfword may change the readback, so this separates a correct lane decode from a decode that matches any halfword or any write. Triggers are then issued against each blocking condition (busy, non-normal mode, error stop) and against the open condition, which shows whether each of the three guards is present on its own. The end events are applied separately and together with clear commands, so the test distinguishes the request-only events from the status-setting one and confirms that a clear wins over a normal end. Pointers at the top of the legal range, with a high base, check the carry through the address adder.

// File: rtl/swtrig_pkg.sv
// Package: shared constants and types for the software-start trigger register.
// Assumes a 2-bit engine mode where all-zero means normal operation.
package swtrig_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_NORMAL = 2'b00,
        MODE_ALT1   = 2'b01,
        MODE_ALT2   = 2'b10,
        MODE_ALT3   = 2'b11
    } eng_mode_e;

    // Engine completion events toward the register.
    typedef struct packed {
        logic norm_end;
        logic abort;
        logic wait_trig;
    } eng_evt_t;

endpackage

// File: rtl/swtrig_qualify.sv
// Module: decides whether a bus write is an accepted start trigger.
// Assumes the pointer field sits in the upper halfword, so only an
// upper-halfword byte-enable pattern may trigger.
module swtrig_qualify
    import swtrig_pkg::*;
#(
    parameter int BE_W = 4
) (
    input  logic              wr_en,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [MODE_W-1:0] eng_mode,
    input  logic              eng_estop,
    input  logic              req_q,
    output logic              accept
);

    localparam int HALF_BE = BE_W / 2;
    localparam logic [BE_W-1:0] TRIG_BE = {{HALF_BE{1'b1}}, {HALF_BE{1'b0}}};

    logic lane_ok;
    logic engine_ok;

    // Only the exact upper-halfword enable pattern counts as a trigger.
    always_comb lane_ok = wr_en && (wr_be == TRIG_BE);

    // Engine must be idle for software work, normal mode, and not halted.
    always_comb engine_ok = !req_q && (eng_mode == MODE_NORMAL) && !eng_estop;

    // Final acceptance.
    always_comb accept = lane_ok && engine_ok;

endmodule

// File: rtl/swtrig_flags.sv
// Module: holds the pointer, request flag and status flag.
// Assumes accept cannot coincide with a chain load (chain needs req=1,
// accept needs req=0); priority is accept > other updates regardless.
module swtrig_flags
    import swtrig_pkg::*;
#(
    parameter int PTR_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic             chain_load,
    input  logic [PTR_W-1:0] chain_ptr,
    input  eng_evt_t         evt,
    input  logic             clr_cmd,
    output logic [PTR_W-1:0] ptr_q,
    output logic             req_q,
    output logic             st_q
);

    logic any_end;

    // Any event that finishes or parks the software transfer.
    always_comb any_end = evt.norm_end || evt.abort || evt.wait_trig;

    // Pointer register: loaded by a trigger, replaced by a chain start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (accept) begin
            ptr_q <= wr_ptr;
        end else if (chain_load && req_q) begin
            ptr_q <= chain_ptr;
        end
    end

    // Request flag: set by trigger, dropped by any end event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (accept) begin
            req_q <= 1'b1;
        end else if (any_end) begin
            req_q <= 1'b0;
        end
    end

    // Status flag: cleared by trigger or commands, set only by normal end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= 1'b0;
        end else if (accept || clr_cmd) begin
            st_q <= 1'b0;
        end else if (evt.norm_end) begin
            st_q <= 1'b1;
        end
    end

endmodule

// File: rtl/swtrig_addr.sv
// Module: forms the descriptor address as base plus zero-extended pointer.
// Assumes the address is at least as wide as the pointer; wraps modulo 2^ADDR_W.
module swtrig_addr #(
    parameter int ADDR_W = 32,
    parameter int PTR_W  = 14
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [PTR_W-1:0]  ptr,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] ptr_ext;

    // Zero-extend the pointer; the variant depends on relative widths.
    generate
        if (ADDR_W > PTR_W) begin : g_ext
            always_comb ptr_ext = {{(ADDR_W-PTR_W){1'b0}}, ptr};
        end else begin : g_same
            always_comb ptr_ext = ptr[ADDR_W-1:0];
        end
    endgenerate

    // Address sum.
    always_comb addr = base + ptr_ext;

endmodule

// File: rtl/sw_start_reg.sv
// Module: software-start trigger register of a DMA engine (top).
// Assumes a DATA_W-bit register with the pointer at PTR_LSB, request flag
// above it and status flag at the top bit; the low field reads as zero.
module sw_start_reg
    import swtrig_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PTR_W   = 14,
    parameter int PTR_LSB = 16,
    parameter int ADDR_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [MODE_W-1:0]   eng_mode,
    input  logic                eng_estop,
    input  logic                evt_norm_end,
    input  logic                evt_abort,
    input  logic                evt_wait,
    input  logic                chain_load,
    input  logic [PTR_W-1:0]    chain_ptr,
    input  logic                cmd_swclr,
    input  logic                cmd_standby,
    input  logic                irq_en,
    input  logic [ADDR_W-1:0]   desc_base,
    output logic                sw_req,
    output logic [ADDR_W-1:0]   desc_addr,
    output logic                irq
);

    localparam int BE_W    = DATA_W / 8;
    localparam int PTR_MSB = PTR_LSB + PTR_W - 1;
    localparam int REQ_BIT = PTR_MSB + 1;
    localparam int ST_BIT  = REQ_BIT + 1;

    logic             accept;
    logic [PTR_W-1:0] ptr_q;
    logic             req_q;
    logic             st_q;
    eng_evt_t         evt;
    logic             clr_cmd;
    logic             unused_wr_bits;

    // Write-data bits outside the pointer field carry no meaning.
    assign unused_wr_bits = ^{wr_data[DATA_W-1:REQ_BIT], wr_data[PTR_LSB-1:0]};

    // Bundle engine events and clear commands.
    always_comb begin
        evt.norm_end  = evt_norm_end;
        evt.abort     = evt_abort;
        evt.wait_trig = evt_wait;
        clr_cmd       = cmd_swclr || cmd_standby;
    end

    swtrig_qualify #(
        .BE_W (BE_W)
    ) u_qualify (
        .wr_en     (wr_en),
        .wr_be     (wr_be),
        .eng_mode  (eng_mode),
        .eng_estop (eng_estop),
        .req_q     (req_q),
        .accept    (accept)
    );

    swtrig_flags #(
        .PTR_W (PTR_W)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .wr_ptr     (wr_data[PTR_MSB:PTR_LSB]),
        .chain_load (chain_load),
        .chain_ptr  (chain_ptr),
        .evt        (evt),
        .clr_cmd    (clr_cmd),
        .ptr_q      (ptr_q),
        .req_q      (req_q),
        .st_q       (st_q)
    );

    swtrig_addr #(
        .ADDR_W (ADDR_W),
        .PTR_W  (PTR_W)
    ) u_addr (
        .base (desc_base),
        .ptr  (ptr_q),
        .addr (desc_addr)
    );

    // Readback assembly: status, request, pointer; low field zero.
    always_comb begin
        rd_data                  = '0;
        rd_data[ST_BIT]          = st_q;
        rd_data[REQ_BIT]         = req_q;
        rd_data[PTR_MSB:PTR_LSB] = ptr_q;
    end

    // Outputs toward the engine and the interrupt controller.
    always_comb begin
        sw_req = req_q;
        irq    = irq_en && st_q;
    end

endmodule

// File: rtl/sw_start_reg_chk.sv
// Checker: port-level properties of the software-start trigger register.
module sw_start_reg_chk #(
    parameter int DATA_W  = 32,
    parameter int PTR_W   = 14,
    parameter int PTR_LSB = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [DATA_W/8-1:0] wr_be,
    input logic [DATA_W-1:0]   wr_data,
    input logic [DATA_W-1:0]   rd_data,
    input logic [1:0]          eng_mode,
    input logic                eng_estop,
    input logic                evt_norm_end,
    input logic                evt_abort,
    input logic                evt_wait,
    input logic                chain_load,
    input logic [PTR_W-1:0]    chain_ptr,
    input logic                cmd_swclr,
    input logic                cmd_standby,
    input logic                irq_en,
    input logic                sw_req,
    input logic                irq
);

    localparam int BE_W    = DATA_W / 8;
    localparam int PTR_MSB = PTR_LSB + PTR_W - 1;
    localparam int ST_BIT  = PTR_MSB + 2;
    localparam logic [BE_W-1:0] TRIG_BE = {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}};

    logic trig_wr;
    logic quiet;
    logic clr;
    logic ends;

    always_comb begin
        trig_wr = wr_en && (wr_be == TRIG_BE);
        clr     = cmd_swclr || cmd_standby;
        ends    = evt_norm_end || evt_abort || evt_wait;
        quiet   = !ends && !chain_load && !clr;
    end

    AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr && !sw_req && eng_mode == 2'b00 && !eng_estop
        |=> sw_req && !rd_data[ST_BIT] && rd_data[PTR_MSB:PTR_LSB] == $past(wr_data[PTR_MSB:PTR_LSB])); // R4

    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr && (sw_req || eng_mode != 2'b00 || eng_estop) && quiet
        |=> $stable(rd_data)); // R3

    AST_LANE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_be != TRIG_BE && quiet
        |=> $stable(rd_data)); // R2

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ends && !trig_wr
        |=> !sw_req); // R7

    AST_CHAIN_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        chain_load && sw_req
        |=> rd_data[PTR_MSB:PTR_LSB] == $past(chain_ptr)); // R6

    AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        evt_norm_end && !clr && !trig_wr
        |=> rd_data[ST_BIT]); // R8

    AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr
        |=> !rd_data[ST_BIT]); // R8

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_en && rd_data[ST_BIT])); // R9

    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[PTR_LSB-1:0] == '0); // R5

endmodule

bind sw_start_reg sw_start_reg_chk #(
    .DATA_W  (DATA_W),
    .PTR_W   (PTR_W),
    .PTR_LSB (PTR_LSB)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_be        (wr_be),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .eng_mode     (eng_mode),
    .eng_estop    (eng_estop),
    .evt_norm_end (evt_norm_end),
    .evt_abort    (evt_abort),
    .evt_wait     (evt_wait),
    .chain_load   (chain_load),
    .chain_ptr    (chain_ptr),
    .cmd_swclr    (cmd_swclr),
    .cmd_standby  (cmd_standby),
    .irq_en       (irq_en),
    .sw_req       (sw_req),
    .irq          (irq)
);

// File: tb/test_sw_start_reg.sv
// Scoreboard bench: the driver models each cycle and queues the expected
// outputs; the monitor pops and compares at the following falling edge.
module test_sw_start_reg;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_be;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [1:0]  eng_mode;
    logic        eng_estop;
    logic        evt_norm_end;
    logic        evt_abort;
    logic        evt_wait;
    logic        chain_load;
    logic [13:0] chain_ptr;
    logic        cmd_swclr;
    logic        cmd_standby;
    logic        irq_en;
    logic [31:0] desc_base;
    logic        sw_req;
    logic [31:0] desc_addr;
    logic        irq;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 1'b0;

    logic [13:0] m_ptr = '0;
    logic        m_req = 1'b0;
    logic        m_st  = 1'b0;

    logic [31:0] q_rd[$];
    logic [31:0] q_addr[$];
    logic        q_irq[$];
    logic        q_req[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    sw_start_reg i_sw_start_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_data(rd_data), .eng_mode(eng_mode), .eng_estop(eng_estop),
        .evt_norm_end(evt_norm_end), .evt_abort(evt_abort), .evt_wait(evt_wait),
        .chain_load(chain_load), .chain_ptr(chain_ptr), .cmd_swclr(cmd_swclr),
        .cmd_standby(cmd_standby), .irq_en(irq_en), .desc_base(desc_base),
        .sw_req(sw_req), .desc_addr(desc_addr), .irq(irq)
    );

    // Driver: one clock cycle with the current inputs; model and queue.
    task automatic tick(input string tag);
        logic acc;
        acc = wr_en && wr_be == 4'b1100 && !m_req && eng_mode == 2'b00 && !eng_estop;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_ptr = '0; m_req = 1'b0; m_st = 1'b0;
        end else if (acc) begin
            m_ptr = wr_data[29:16]; m_req = 1'b1; m_st = 1'b0;
        end else begin
            if (chain_load && m_req) m_ptr = chain_ptr;
            if (evt_norm_end || evt_abort || evt_wait) m_req = 1'b0;
            if (cmd_swclr || cmd_standby) m_st = 1'b0;
            else if (evt_norm_end) m_st = 1'b1;
        end
        q_rd.push_back({m_st, m_req, m_ptr, 16'h0000});
        q_addr.push_back(desc_base + {18'b0, m_ptr});
        q_irq.push_back(irq_en && m_st);
        q_req.push_back(m_req);
        q_tag.push_back(tag);
        @(negedge clk);
        #1;
        wr_en = 0; wr_be = '0; wr_data = '0;
        evt_norm_end = 0; evt_abort = 0; evt_wait = 0;
        chain_load = 0; cmd_swclr = 0; cmd_standby = 0;
    endtask

    task automatic write(input logic [3:0] be, input logic [31:0] data, input string tag);
        wr_en = 1; wr_be = be; wr_data = data;
        tick(tag);
    endtask

    // Monitor: compare the design's outputs against the queued expectation.
    always @(negedge clk) begin
        if (q_rd.size() > 0) begin
            logic [31:0] e_rd, e_addr;
            logic        e_irq, e_req;
            string       tg;
            e_rd = q_rd.pop_front(); e_addr = q_addr.pop_front();
            e_irq = q_irq.pop_front(); e_req = q_req.pop_front();
            tg = q_tag.pop_front();
            compared++;
            if (rd_data !== e_rd || desc_addr !== e_addr || irq !== e_irq || sw_req !== e_req) begin
                mismatched++;
                $display("FAIL %s: rd=%h addr=%h irq=%b req=%b expected rd=%h addr=%h irq=%b req=%b",
                         tg, rd_data, desc_addr, irq, sw_req, e_rd, e_addr, e_irq, e_req);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; wr_be = '0; wr_data = '0; eng_mode = 2'b00; eng_estop = 0;
        evt_norm_end = 0; evt_abort = 0; evt_wait = 0; chain_load = 0; chain_ptr = '0;
        cmd_swclr = 0; cmd_standby = 0; irq_en = 1; desc_base = 32'h2000_0000;
        tick("R1 reset");
        tick("R1 reset hold");
        rst_n = 1;
        tick("R1 idle after reset");

        write(4'b1111, 32'h0120_0000, "R2 word write ignored");
        write(4'b0011, 32'h0120_0120, "R2 lower halfword ignored");
        write(4'b1100, 32'hC120_FFFF, "R4 R5 R10 accepted trigger");
        write(4'b1100, 32'h0200_0000, "R3 rejected while busy");
        chain_ptr = 14'h0340; chain_load = 1; tick("R6 chain pointer update");
        evt_norm_end = 1; tick("R7 R8 R9 normal end");
        irq_en = 0; tick("R9 interrupt masked");
        irq_en = 1; tick("R9 interrupt unmasked");
        chain_ptr = 14'h0100; chain_load = 1; tick("R6 chain ignored when idle");
        cmd_swclr = 1; tick("R8 software clear");

        eng_mode = 2'b01; write(4'b1100, 32'h0050_0000, "R3 rejected in mode 01");
        eng_mode = 2'b00; eng_estop = 1; write(4'b1100, 32'h0060_0000, "R3 rejected in error stop");
        eng_estop = 0; write(4'b1100, 32'h0070_0000, "R4 accepted after guards lift");
        evt_abort = 1; tick("R7 R8 abort drops request only");
        write(4'b1100, 32'h0080_0000, "R4 accepted again");
        evt_wait = 1; tick("R7 wait drops request");

        write(4'b1100, 32'h0090_0000, "R4 trigger before end");
        evt_norm_end = 1; tick("R8 status set");
        write(4'b1100, 32'h00A0_0000, "R4 accepted write clears status");
        evt_norm_end = 1; cmd_standby = 1; tick("R8 standby clear beats normal end");

        desc_base = 32'hFFFF_C000;
        write(4'b1100, 32'h3FF0_0000, "R10 max pointer address");
        desc_base = 32'hFFFF_F000; tick("R10 address wraps");
        evt_norm_end = 1; tick("R8 R9 final completion");
        rst_n = 0; tick("R1 reset clears state");

        @(negedge clk);
        #2;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule